// File: doc/BRIEF.md
# Backplane Interrupter with Status/ID Response

This block lets local logic raise one interrupt request on a backplane that has seven prioritized levels, then answer the matching interrupt-acknowledge cycle with a status/ID word. Local software uses one write port with three targets. The first holds a small logical address. The second holds an 8-bit response byte. The third is a generator register: writing a level to it raises the request on that level.

When a backplane master runs an acknowledge cycle, the block compares the level on the bus with the level it is requesting. On a match it drives the status/ID word and then strobes its acknowledge. It drops its request in the same cycle, which makes it a release-on-acknowledge interrupter. The word it drives depends on the width of the cycle. A byte-wide cycle returns only the address byte, which is five ones followed by the address. A 16-bit or 32-bit cycle also places the response byte in the upper half. When the block is not the one being asked, it hands the acknowledge on through a pass output.

Top module: `sid_responder`

## Requirements
- R1: While reset is held and right after it is released, every request line, the data-enable, the acknowledge and the pass output are low, and the address field and response byte are zero.
- R2: A generator write (select 2'b10) whose data bits [2:0] hold a level L from 1 to 7 raises request line bit L-1 alone in the next cycle. A write with level 0 raises nothing.
- R3: A generator write made while a request is pending changes neither the pending level nor the request lines.
- R4: A byte-wide acknowledge (width code 2'b00) returns status/ID bits [7:0] = {5'b11111, address} and bits [15:8] = 0. The address is written with select 2'b00 from data bits [2:0].
- R5: A 16-bit (width code 2'b01) or 32-bit (2'b10) acknowledge returns the response byte in bits [15:8] and {5'b11111, address} in bits [7:0]. The response byte is written with select 2'b01.
- R6: An acknowledge whose level differs from the pending level, or that arrives when nothing is pending, is ignored. The pass output goes high in that cycle, nothing is driven or acknowledged, and the request stays as it was.
- R7: A matching acknowledge sampled at a clock edge turns on data-enable after that edge. The acknowledge output follows one cycle later. The data stays unchanged for as long as data-enable is high.
- R8: The request line drops in the same cycle in which the acknowledge output rises.
- R9: Once the acknowledge strobe is withdrawn, data-enable and the acknowledge output are low after the next clock edge.
- R10: Writes to the address field or the response byte during a response do not change the word being driven.
- R11: A generator write that lands on the clock edge at which the request is released is dropped, so no request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Local write strobe |
| wr_sel | input | 2 | Write target: 00 address, 01 response byte, 10 generator |
| wr_data | input | 8 | Local write data |
| iack_strb | input | 1 | Acknowledge cycle in progress (held until released) |
| iack_lvl | input | 3 | Level being acknowledged |
| iack_width | input | 2 | Cycle width: 00 byte, 01 16-bit, 10 32-bit |
| irq_lines | output | 7 | Request lines, bit i is level i+1 |
| sid_oe | output | 1 | Status/ID data is driven |
| sid_data | output | 16 | Status/ID word |
| sid_dtack | output | 1 | Acknowledge to the bus master |
| iack_pass | output | 1 | Non-matching acknowledge handed onward |

## Verification
Two events can fall on the same clock edge: the release of a pending request, and a new generator write that would raise another request. The bench triggers this by issuing a generator write in the cycle when data-enable is high but the acknowledge is still low. That write is sampled at the very edge where the acknowledge rises. The outcome is judged at the ports: after the cycle completes, the request lines must be all zero. Register writes issued in the middle of a response are also checked, and the driven word must not change.

// File: rtl/sid_pkg.sv
package sid_pkg;
   typedef enum logic [1:0] {
      W_BYTE = 2'b00,
      W_HALF = 2'b01,
      W_WORD = 2'b10,
      W_RSVD = 2'b11
   } ack_width_t;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'b00,
      SEL_RESP = 2'b01,
      SEL_GEN  = 2'b10,
      SEL_NONE = 2'b11
   } wr_sel_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_DRIVE = 2'b01,
      ST_HOLD  = 2'b10
   } resp_state_t;
endpackage

// File: rtl/sid_regs.sv
module sid_regs #(
   parameter int LA_W   = 3,
   parameter int LVL_W  = 3,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  sid_pkg::wr_sel_t    wr_sel,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic                release_i,
   output logic [LA_W-1:0]     la_q,
   output logic [BYTE_W-1:0]   resp_q,
   output logic                pend_q,
   output logic [LVL_W-1:0]    lvl_q
);
   import sid_pkg::*;

   logic [LVL_W-1:0] wr_lvl;
   logic             gen_take;
   logic             unused_hi;

   assign wr_lvl    = wr_data[LVL_W-1:0];
   assign gen_take  = wr_en && (wr_sel == SEL_GEN) && !pend_q && (wr_lvl != '0);
   assign unused_hi = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         la_q   <= '0;
         resp_q <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_ADDR) la_q   <= wr_data[LA_W-1:0];
         if (wr_sel == SEL_RESP) resp_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         lvl_q  <= '0;
      end else if (gen_take) begin
         pend_q <= 1'b1;
         lvl_q  <= wr_lvl;
      end else if (release_i) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sid_irq_drive.sv
module sid_irq_drive #(
   parameter int LVL_W  = 3,
   parameter int LEVELS = (1 << LVL_W) - 1
) (
   input  logic              pend_i,
   input  logic [LVL_W-1:0]  lvl_i,
   output logic [LEVELS-1:0] irq_o
);
   for (genvar g = 0; g < LEVELS; g++) begin : g_line
      localparam logic [LVL_W-1:0] MY_LVL = LVL_W'(g + 1);
      assign irq_o[g] = pend_i && (lvl_i == MY_LVL);
   end
endmodule

// File: rtl/sid_resp.sv
module sid_resp #(
   parameter int LA_W     = 3,
   parameter int LVL_W    = 3,
   parameter int BYTE_W   = 8,
   parameter bit PASS_REG = 1'b0,
   localparam int PFX_W   = BYTE_W - LA_W,
   localparam int SID_W   = 2 * BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  strb_i,
   input  logic [LVL_W-1:0]      lvl_i,
   input  sid_pkg::ack_width_t   width_i,
   input  logic                  pend_i,
   input  logic [LVL_W-1:0]      pend_lvl_i,
   input  logic [LA_W-1:0]       la_i,
   input  logic [BYTE_W-1:0]     resp_i,
   output logic                  oe_o,
   output logic                  dtack_o,
   output logic [SID_W-1:0]      data_o,
   output logic                  release_o,
   output logic                  pass_o
);
   import sid_pkg::*;

   resp_state_t       state_q, state_d;
   logic [SID_W-1:0]  data_q;
   logic [SID_W-1:0]  word_d;
   logic [BYTE_W-1:0] id_byte;
   logic              match;
   logic              pass_raw;

   assign match   = strb_i && pend_i && (lvl_i == pend_lvl_i);
   assign id_byte = {{PFX_W{1'b1}}, la_i};

   always_comb begin
      if (width_i == W_BYTE) word_d = {{BYTE_W{1'b0}}, id_byte};
      else                   word_d = {resp_i, id_byte};
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (match) state_d = ST_DRIVE;
         ST_DRIVE: state_d = ST_HOLD;
         ST_HOLD:  if (!strb_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         data_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && match) data_q <= word_d;
      end
   end

   assign oe_o      = (state_q != ST_IDLE);
   assign dtack_o   = (state_q == ST_HOLD);
   assign release_o = (state_q == ST_DRIVE);
   assign data_o    = oe_o ? data_q : '0;
   assign pass_raw  = strb_i && (state_q == ST_IDLE) && !match;

   if (PASS_REG) begin : g_pass_reg
      logic pass_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pass_q <= 1'b0;
         else        pass_q <= pass_raw;
      end
      assign pass_o = pass_q;
   end else begin : g_pass_comb
      assign pass_o = pass_raw;
   end
endmodule

// File: rtl/sid_responder.sv
module sid_responder #(
   parameter int LA_W     = 3,
   parameter int LVL_W    = 3,
   parameter int BYTE_W   = 8,
   parameter bit PASS_REG = 1'b0,
   localparam int LEVELS  = (1 << LVL_W) - 1,
   localparam int SID_W   = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              iack_strb,
   input  logic [LVL_W-1:0]  iack_lvl,
   input  logic [1:0]        iack_width,
   output logic [LEVELS-1:0] irq_lines,
   output logic              sid_oe,
   output logic [SID_W-1:0]  sid_data,
   output logic              sid_dtack,
   output logic              iack_pass
);
   import sid_pkg::*;

   if (LA_W < 1 || LA_W >= BYTE_W) begin : g_bad_la
      $error("LA_W must lie between 1 and BYTE_W-1");
   end
   if (LVL_W < 1 || LVL_W > BYTE_W) begin : g_bad_lvl
      $error("LVL_W must lie between 1 and BYTE_W");
   end

   logic [LA_W-1:0]   la_q;
   logic [BYTE_W-1:0] resp_q;
   logic              pend_q;
   logic [LVL_W-1:0]  lvl_q;
   logic              release_w;

   sid_regs #(.LA_W(LA_W), .LVL_W(LVL_W), .BYTE_W(BYTE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel_t'(wr_sel)),
      .wr_data   (wr_data),
      .release_i (release_w),
      .la_q      (la_q),
      .resp_q    (resp_q),
      .pend_q    (pend_q),
      .lvl_q     (lvl_q)
   );

   sid_irq_drive #(.LVL_W(LVL_W), .LEVELS(LEVELS)) u_irq (
      .pend_i (pend_q),
      .lvl_i  (lvl_q),
      .irq_o  (irq_lines)
   );

   sid_resp #(.LA_W(LA_W), .LVL_W(LVL_W), .BYTE_W(BYTE_W), .PASS_REG(PASS_REG)) u_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .strb_i     (iack_strb),
      .lvl_i      (iack_lvl),
      .width_i    (ack_width_t'(iack_width)),
      .pend_i     (pend_q),
      .pend_lvl_i (lvl_q),
      .la_i       (la_q),
      .resp_i     (resp_q),
      .oe_o       (sid_oe),
      .dtack_o    (sid_dtack),
      .data_o     (sid_data),
      .release_o  (release_w),
      .pass_o     (iack_pass)
   );
endmodule

// File: rtl/sid_responder_chk.sv
module sid_responder_chk #(
   parameter int LEVELS = 7,
   parameter int SID_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iack_strb,
   input logic [1:0]        iack_width,
   input logic [LEVELS-1:0] irq_lines,
   input logic              sid_oe,
   input logic [SID_W-1:0]  sid_data,
   input logic              sid_dtack,
   input logic              iack_pass
);
   p_onehot_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_lines));

   p_prefix_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sid_oe |-> (sid_data[7:3] == 5'b11111));

   p_pass_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      iack_pass |-> (!sid_oe && !sid_dtack));

   p_ack_with_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sid_dtack |-> sid_oe);

   p_oe_leads_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sid_dtack) |-> $past(sid_oe));

   p_data_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sid_oe && $past(sid_oe)) |-> $stable(sid_data));

   p_req_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sid_dtack) |-> (irq_lines == '0));

   p_strobe_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sid_dtack && !iack_strb) |=> !sid_dtack);

   logic unused_w;
   assign unused_w = ^iack_width;
endmodule

bind sid_responder sid_responder_chk #(.LEVELS(LEVELS), .SID_W(SID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .iack_strb  (iack_strb),
   .iack_width (iack_width),
   .irq_lines  (irq_lines),
   .sid_oe     (sid_oe),
   .sid_data   (sid_data),
   .sid_dtack  (sid_dtack),
   .iack_pass  (iack_pass)
);

// File: tb/sid_responder_bench.sv
module sid_responder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'b11;
   logic [7:0]  wr_data = 8'h00;
   logic        iack_strb = 1'b0;
   logic [2:0]  iack_lvl = 3'd0;
   logic [1:0]  iack_width = 2'b00;
   logic [6:0]  irq_lines;
   logic        sid_oe;
   logic [15:0] sid_data;
   logic        sid_dtack;
   logic        iack_pass;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] exp_q[$];
   logic prev_dtack = 1'b0;

   always #2 clk = ~clk;

   sid_responder u_sid_responder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .iack_strb(iack_strb), .iack_lvl(iack_lvl), .iack_width(iack_width),
      .irq_lines(irq_lines), .sid_oe(sid_oe), .sid_data(sid_data),
      .sid_dtack(sid_dtack), .iack_pass(iack_pass)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: on the first cycle of an acknowledge, pop and compare
   always @(negedge clk) begin
      if (rst_n && sid_dtack && !prev_dtack) begin
         if (exp_q.size() == 0) chk(1'b0, "R4/R5 unexpected ack", sid_data, 16'h0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(sid_data == e, "R4/R5 status/ID word", sid_data, e);
         end
      end
      prev_dtack = sid_dtack;
   end

   task automatic write_reg(input logic [1:0] sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'b11;
   endtask

   // mode 0: plain, 1: register writes during response (R10), 2: generator write at release (R11)
   task automatic iack(input logic [2:0] lvl, input logic [1:0] w, input logic [15:0] exp, input int mode);
      logic [6:0] irq_before;
      irq_before = irq_lines;
      exp_q.push_back(exp);
      iack_strb = 1'b1; iack_lvl = lvl; iack_width = w;
      @(negedge clk);
      chk(sid_oe && !sid_dtack, "R7 data before ack", {14'b0, sid_oe, sid_dtack}, 16'h2);
      chk(irq_lines == irq_before, "R8 request held while driving", {9'b0, irq_lines}, {9'b0, irq_before});
      if (mode == 1) begin wr_en = 1'b1; wr_sel = 2'b01; wr_data = 8'h11; end
      if (mode == 2) begin wr_en = 1'b1; wr_sel = 2'b10; wr_data = 8'h04; end
      @(negedge clk);
      wr_en = 1'b0; wr_sel = 2'b11;
      chk(sid_dtack && sid_oe, "R7 ack raised", {14'b0, sid_oe, sid_dtack}, 16'h3);
      chk(irq_lines == 7'b0, "R8 request dropped with ack", {9'b0, irq_lines}, 16'h0);
      if (mode == 1) begin
         wr_en = 1'b1; wr_sel = 2'b00; wr_data = 8'h02;
         @(negedge clk);
         wr_en = 1'b0; wr_sel = 2'b11;
         chk(sid_data == exp, "R10 word unchanged by writes", sid_data, exp);
      end
      iack_strb = 1'b0;
      @(negedge clk);
      chk(!sid_oe && !sid_dtack, "R9 released after strobe drop", {14'b0, sid_oe, sid_dtack}, 16'h0);
      if (mode == 2)
         chk(irq_lines == 7'b0, "R11 generator write at release dropped", {9'b0, irq_lines}, 16'h0);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         chk(1'b0, "watchdog expired", 16'h0, 16'h1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(irq_lines == 0 && !sid_oe && !sid_dtack && !iack_pass, "R1 reset outputs",
          {9'b0, irq_lines}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_lines == 0 && !sid_oe && !sid_dtack && !iack_pass, "R1 after reset",
          {9'b0, irq_lines}, 16'h0);

      // R1: registers zero -> byte-wide id is F8 with address 0
      write_reg(2'b10, 8'h05);
      chk(irq_lines == 7'b0010000, "R2 level 5 request", {9'b0, irq_lines}, 16'h0010);
      iack(3'd5, 2'b00, 16'h00F8, 0);

      write_reg(2'b00, 8'h05);
      write_reg(2'b01, 8'hA7);
      write_reg(2'b10, 8'h03);
      chk(irq_lines == 7'b0000100, "R2 level 3 request", {9'b0, irq_lines}, 16'h0004);
      write_reg(2'b10, 8'h06);
      chk(irq_lines == 7'b0000100, "R3 second write ignored", {9'b0, irq_lines}, 16'h0004);

      // R6: wrong level
      iack_strb = 1'b1; iack_lvl = 3'd2; iack_width = 2'b00;
      #1;
      chk(iack_pass, "R6 pass on mismatch", {15'b0, iack_pass}, 16'h1);
      @(negedge clk);
      chk(!sid_oe && !sid_dtack && iack_pass, "R6 no response on mismatch",
          {13'b0, sid_oe, sid_dtack, iack_pass}, 16'h1);
      chk(irq_lines == 7'b0000100, "R6 request kept", {9'b0, irq_lines}, 16'h0004);
      iack_strb = 1'b0;
      @(negedge clk);

      iack(3'd3, 2'b00, 16'h00FD, 0);

      write_reg(2'b10, 8'h00);
      chk(irq_lines == 7'b0, "R2 level 0 no request", {9'b0, irq_lines}, 16'h0);

      // R6: no request pending
      iack_strb = 1'b1; iack_lvl = 3'd3; iack_width = 2'b01;
      @(negedge clk);
      chk(!sid_oe && iack_pass, "R6 nothing pending", {14'b0, sid_oe, iack_pass}, 16'h1);
      iack_strb = 1'b0;
      @(negedge clk);

      write_reg(2'b10, 8'h07);
      chk(irq_lines == 7'b1000000, "R2 level 7 request", {9'b0, irq_lines}, 16'h0040);
      iack(3'd7, 2'b01, 16'hA7FD, 1);

      write_reg(2'b10, 8'h01);
      chk(irq_lines == 7'b0000001, "R2 level 1 request", {9'b0, irq_lines}, 16'h0001);
      iack(3'd1, 2'b10, 16'h11FA, 2);

      write_reg(2'b10, 8'h02);
      iack(3'd2, 2'b00, 16'h00FA, 0);
      write_reg(2'b10, 8'h04);
      iack(3'd4, 2'b01, 16'h11FA, 0);

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all responses seen", 16'(exp_q.size()), 16'h0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule